// File: doc/BRIEF.md
# Half-Precision 2x2 Matrix Multiply-Accumulate Unit

This unit takes two 128-bit source vectors and a 128-bit accumulator. Each vector splits into two independent 64-bit segments, and each segment carries four half-precision (FP16) numbers that form one 2x2 matrix. For each segment the unit multiplies the first-source matrix by the transpose of the second-source matrix and adds the accumulator matrix. The 128-bit sum then replaces the accumulator value. Every output element is a two-term dot product plus one accumulator term. The result is rounded three times: once after each product, once after the pairwise sum, and once after the accumulate.

The unit is sequential. One FP16 multiplier and one FP16 adder are shared across all eight output elements, and a small controller schedules the work. Operands are taken with a valid/ready handshake. The result is offered with `outValid` and held until the consumer accepts it. A feature-enable input decides at acceptance whether the operation runs at all. When it is low, the unit reports an undefined operation and does no arithmetic.

Top module: `fmma_unit`

## Requirements
- R1: Element k (0..3) of segment s sits at bits [64s+16k+15 : 64s+16k], stored row-major so that element 2i+j is row i, column j. The result element is C[i][j] = Acc[i][j] + A[i][0]*B[j][0] + A[i][1]*B[j][1], using only segment s of every operand. All 128 result bits are written.
- R2: Every rounding is round-to-nearest, ties-to-even. Each of the two products is rounded to FP16 first, then their sum is rounded, then the sum plus the accumulator is rounded. For example, 2048 + 1 gives 0x6800 and 2050 + 1 gives 0x6802.
- R3: If the rounded exponent of a result exceeds the FP16 range, the result is infinity with the sign of the exact value (0x7C00 or 0xFC00). A valid operation on an infinite operand gives a signed infinity.
- R4: A NaN operand, infinity times zero, or infinity plus infinity of opposite signs gives exactly 0x7E00. No other NaN encoding ever appears in a computed result.
- R5: An operand whose exponent field is 0 counts as a zero of its own sign. A result whose rounded value is below 2^-14 in magnitude becomes a zero carrying the sign of the exact value. A computed result is never subnormal.
- R6: An exact cancellation to zero in a sum gives +0 (0x0000). A sum of two negative zeros gives -0 (0x8000). A product involving a zero gives a zero whose sign is the XOR of the operand signs.
- R7: If `featEn` is low when an operation is accepted, nothing is computed. `outValid` is high in the cycle right after the accepting edge, with `undefFlag`=1 and `result` equal to the accepted accumulator operand.
- R8: `inReady` is high only while the unit is idle, and an operation is accepted on a clock edge where `inValid` and `inReady` are both high. For an enabled operation, `outValid` first appears after the 32nd clock edge following the accepting edge. `result` and `undefFlag` stay stable while `outValid` is high and `outReady` is low. The unit returns to idle on the edge where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand set is offered |
| inReady | output | 1 | Unit is idle and takes an operand set |
| featEn | input | 1 | Operation enabled; sampled at acceptance |
| opA | input | 128 | First source vector (two 2x2 FP16 matrices) |
| opB | input | 128 | Second source vector (two 2x2 FP16 matrices) |
| opAcc | input | 128 | Accumulator vector |
| outValid | output | 1 | Result is available |
| outReady | input | 1 | Consumer takes the result |
| result | output | 128 | New accumulator value |
| undefFlag | output | 1 | Operation was not enabled; valid with outValid |

## Verification
The hardest behaviour to reach from the ports is the rounding that happens between stages. A discrepancy only shows when a product or pairwise sum lands exactly on, or just beside, a halfway point that the next rounding step would have resolved differently. Random operands spread over a narrow exponent window make products and sums collide often. Directed vectors then force exact ties in the accumulate step, cancellation to signed zero, overflow inside a product, and NaN or subnormal inputs confined to one segment. All of these are compared against a reference built from exact real arithmetic with the same three rounding points.

// File: rtl/fmma_pkg.sv
`timescale 1ns/1ps
package fmma_pkg;
  localparam int HALF_W        = 16;
  localparam int ELEMS_PER_SEG = 4;
  localparam int SEG_W         = HALF_W * ELEMS_PER_SEG;
  localparam int SEG_COUNT     = 2;
  localparam int VEC_W         = SEG_W * SEG_COUNT;
  localparam int ELEM_COUNT    = ELEMS_PER_SEG * SEG_COUNT;
  localparam int ELEM_IDX_W    = $clog2(ELEM_COUNT);
  localparam int STEP_COUNT    = 4;
  localparam int STEP_W        = $clog2(STEP_COUNT);
  localparam int CNT_W         = ELEM_IDX_W + STEP_W;
  // subnormal operands and results are treated as signed zero
  localparam bit FLUSH_SUBNORMALS = 1'b1;
  localparam logic [HALF_W-1:0] QNAN = 16'h7E00;

  typedef logic [HALF_W-1:0] half_t;

  typedef enum logic [STEP_W-1:0] {
    STEP_MUL_LO = 2'd0,
    STEP_MUL_HI = 2'd1,
    STEP_PAIR   = 2'd2,
    STEP_ACC    = 2'd3
  } step_e;

  typedef struct packed {
    logic                  load;
    logic                  run;
    step_e                 step;
    logic [ELEM_IDX_W-1:0] elem;
  } strobes_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} state_e;
endpackage

// File: rtl/fmma_mul16.sv
`timescale 1ns/1ps
module fmma_mul16 import fmma_pkg::*; (
  input  half_t a,
  input  half_t b,
  output half_t p
);
  logic        sgn, aNan, bNan, aInf, bInf, aZero, bZero, guardBit, stickyBit, roundUp;
  logic [21:0] prod;
  logic [10:0] mant;
  logic [11:0] mantRnd;
  int          expI;

  always_comb begin
    sgn   = a[15] ^ b[15];
    aNan  = (&a[14:10]) && (|a[9:0]);
    bNan  = (&b[14:10]) && (|b[9:0]);
    aInf  = (&a[14:10]) && !(|a[9:0]);
    bInf  = (&b[14:10]) && !(|b[9:0]);
    aZero = !(|a[14:10]);
    bZero = !(|b[14:10]);
    prod  = 22'({1'b1, a[9:0]}) * 22'({1'b1, b[9:0]});
    expI  = int'(a[14:10]) + int'(b[14:10]) - 15;
    if (prod[21]) begin
      mant = prod[21:11]; guardBit = prod[10]; stickyBit = |prod[9:0]; expI = expI + 1;
    end else begin
      mant = prod[20:10]; guardBit = prod[9];  stickyBit = |prod[8:0];
    end
    roundUp = guardBit & (stickyBit | mant[0]);
    mantRnd = {1'b0, mant} + {11'b0, roundUp};
    if (mantRnd[11]) expI = expI + 1;

    if (aNan || bNan || (aInf && bZero) || (bInf && aZero)) p = QNAN;
    else if (aInf || bInf)   p = {sgn, 5'h1F, 10'h0};
    else if (aZero || bZero) p = {sgn, 15'h0};
    else if (expI >= 31)     p = {sgn, 5'h1F, 10'h0};
    else if (expI < 1)       p = {sgn, 15'h0};
    else                     p = {sgn, 5'(expI), mantRnd[9:0]};
  end
endmodule

// File: rtl/fmma_add16.sv
`timescale 1ns/1ps
module fmma_add16 import fmma_pkg::*; (
  input  half_t a,
  input  half_t b,
  output half_t s
);
  logic        aNan, bNan, aInf, bInf, aZero, bZero, aBig, effSub, guardBit, stickyBit, roundUp;
  half_t       big, sml;
  logic [42:0] xs, ys, sum, norm;
  logic [11:0] mantRnd;
  int          shiftAmt, lead, expI;

  always_comb begin
    aNan  = (&a[14:10]) && (|a[9:0]);
    bNan  = (&b[14:10]) && (|b[9:0]);
    aInf  = (&a[14:10]) && !(|a[9:0]);
    bInf  = (&b[14:10]) && !(|b[9:0]);
    aZero = !(|a[14:10]);
    bZero = !(|b[14:10]);
    aBig  = a[14:0] >= b[14:0];
    big   = aBig ? a : b;
    sml   = aBig ? b : a;
    effSub   = a[15] ^ b[15];
    shiftAmt = int'(big[14:10]) - int'(sml[14:10]);
    // exact alignment: the larger operand is shifted up instead of the smaller one down
    xs  = 43'({1'b1, big[9:0]}) << shiftAmt;
    ys  = 43'({1'b1, sml[9:0]});
    sum = effSub ? (xs - ys) : (xs + ys);
    lead = 0;
    for (int i = 0; i < 43; i++) if (sum[i]) lead = i;
    norm      = sum << (42 - lead);
    guardBit  = norm[31];
    stickyBit = |norm[30:0];
    roundUp   = guardBit & (stickyBit | norm[32]);
    mantRnd   = {1'b0, norm[42:32]} + {11'b0, roundUp};
    expI      = int'(sml[14:10]) + lead - 10;
    if (mantRnd[11]) expI = expI + 1;

    if (aNan || bNan || (aInf && bInf && effSub)) s = QNAN;
    else if (aInf)            s = a;
    else if (bInf)            s = b;
    else if (aZero && bZero)  s = {a[15] & b[15], 15'h0};
    else if (aZero)           s = b;
    else if (bZero)           s = a;
    else if (sum == '0)       s = 16'h0000;
    else if (expI >= 31)      s = {big[15], 5'h1F, 10'h0};
    else if (expI < 1)        s = {big[15], 15'h0};
    else                      s = {big[15], 5'(expI), mantRnd[9:0]};
  end
endmodule

// File: rtl/fmma_datapath.sv
`timescale 1ns/1ps
module fmma_datapath import fmma_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         ctl,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [VEC_W-1:0] opAcc,
  output logic [VEC_W-1:0] result
);
  logic [VEC_W-1:0]      aReg, bReg, accReg;
  half_t                 prodLo, prodHi, pairSum, mulX, mulY, mulOut, addX, addY, addOut;
  logic                  kSel;
  logic [ELEM_IDX_W-1:0] aIdx, bIdx;

  // operand lane: same segment, row of A / row of B (i.e. column of B transposed)
  always_comb begin
    kSel = (ctl.step == STEP_MUL_HI);
    aIdx = {ctl.elem[ELEM_IDX_W-1:2], ctl.elem[1], kSel};
    bIdx = {ctl.elem[ELEM_IDX_W-1:2], ctl.elem[0], kSel};
    mulX = aReg[int'(aIdx)*HALF_W +: HALF_W];
    mulY = bReg[int'(bIdx)*HALF_W +: HALF_W];
    addX = (ctl.step == STEP_PAIR) ? prodLo : accReg[int'(ctl.elem)*HALF_W +: HALF_W];
    addY = (ctl.step == STEP_PAIR) ? prodHi : pairSum;
  end

  fmma_mul16 i_mul (.a(mulX), .b(mulY), .p(mulOut));
  fmma_add16 i_add (.a(addX), .b(addY), .s(addOut));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg <= '0; bReg <= '0; accReg <= '0;
      prodLo <= '0; prodHi <= '0; pairSum <= '0;
    end else if (ctl.load) begin
      aReg <= opA; bReg <= opB; accReg <= opAcc;
    end else if (ctl.run) begin
      case (ctl.step)
        STEP_MUL_LO: prodLo  <= mulOut;
        STEP_MUL_HI: prodHi  <= mulOut;
        STEP_PAIR:   pairSum <= addOut;
        default:     accReg[int'(ctl.elem)*HALF_W +: HALF_W] <= addOut;
      endcase
    end
  end

  assign result = accReg;
endmodule

// File: rtl/fmma_ctrl.sv
`timescale 1ns/1ps
module fmma_ctrl import fmma_pkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     featEn,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output logic     undefFlag,
  output strobes_t ctl
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ELEM_COUNT * STEP_COUNT - 1);

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept = inValid && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; cnt <= '0; undefFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          cnt       <= '0;
          undefFlag <= !featEn;
          state     <= featEn ? ST_BUSY : ST_DONE;
        end
        ST_BUSY: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_CNT) state <= ST_DONE;
        end
        ST_DONE: if (outReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign inReady  = (state == ST_IDLE);
  assign outValid = (state == ST_DONE);
  always_comb begin
    ctl.load = accept;
    ctl.run  = (state == ST_BUSY);
    ctl.step = step_e'(cnt[STEP_W-1:0]);
    ctl.elem = cnt[CNT_W-1:STEP_W];
  end
endmodule

// File: rtl/fmma_unit.sv
`timescale 1ns/1ps
module fmma_unit import fmma_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             featEn,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [VEC_W-1:0] opAcc,
  output logic             outValid,
  input  logic             outReady,
  output logic [VEC_W-1:0] result,
  output logic             undefFlag
);
  strobes_t ctl;

  fmma_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .featEn(featEn), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .undefFlag(undefFlag), .ctl(ctl)
  );

  fmma_datapath i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opA(opA), .opB(opB), .opAcc(opAcc), .result(result)
  );
endmodule

// File: rtl/fmma_unit_chk.sv
`timescale 1ns/1ps
module fmma_unit_chk import fmma_pkg::*; (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             featEn,
  input logic [VEC_W-1:0] opAcc,
  input logic             outValid,
  input logic             outReady,
  input logic [VEC_W-1:0] result,
  input logic             undefFlag
);
  logic [VEC_W-1:0] accCapt;

  always_ff @(posedge clk) begin
    if (!rstN) accCapt <= '0;
    else if (inValid && inReady) accCapt <= opAcc;
  end

  function automatic bit nanCanonical(input logic [VEC_W-1:0] v);
    bit ok = 1'b1;
    for (int e = 0; e < ELEM_COUNT; e++)
      if ((&v[e*HALF_W+10 +: 5]) && (|v[e*HALF_W +: 10]) && (v[e*HALF_W +: HALF_W] != QNAN)) ok = 1'b0;
    return ok;
  endfunction

  function automatic bit noSubnormal(input logic [VEC_W-1:0] v);
    bit ok = 1'b1;
    for (int e = 0; e < ELEM_COUNT; e++)
      if (!(|v[e*HALF_W+10 +: 5]) && (|v[e*HALF_W +: 10])) ok = 1'b0;
    return ok;
  endfunction

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(result) && $stable(undefFlag)); // R8
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady); // R8
  AST_ENABLED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && featEn |=> !outValid && !inReady); // R8
  AST_UNDEF_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && !featEn |=> outValid && undefFlag); // R7
  AST_UNDEF_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    outValid && undefFlag |-> result == accCapt); // R7
  AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !undefFlag |-> nanCanonical(result)); // R4
  AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !undefFlag |-> noSubnormal(result)); // R5
endmodule

bind fmma_unit fmma_unit_chk i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .featEn(featEn),
  .opAcc(opAcc), .outValid(outValid), .outReady(outReady), .result(result), .undefFlag(undefFlag)
);

// File: tb/test_fmma_unit.sv
`timescale 1ns/1ps
module test_fmma_unit;
  import fmma_pkg::*;

  logic         clk = 1'b0, rstN = 1'b0;
  logic         inValid = 1'b0, featEn = 1'b0, outReady = 1'b0;
  logic [127:0] opA = '0, opB = '0, opAcc = '0;
  logic         inReady, outValid, undefFlag;
  logic [127:0] result;
  int           checks = 0, fails = 0;

  always #2 clk = ~clk;

  fmma_unit i_fmma_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .featEn(featEn),
    .opA(opA), .opB(opB), .opAcc(opAcc), .outValid(outValid), .outReady(outReady),
    .result(result), .undefFlag(undefFlag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference: exact reals, three rounding points
  function automatic bit isZ(half_t h);   return FLUSH_SUBNORMALS && (h[14:10] == 5'd0); endfunction
  function automatic bit isNan(half_t h); return (h[14:10] == 5'h1F) && (h[9:0] != 0); endfunction
  function automatic bit isInf(half_t h); return (h[14:10] == 5'h1F) && (h[9:0] == 0); endfunction

  function automatic real toReal(half_t h);
    real m = (1024.0 + real'(h[9:0])) / 1024.0;
    int  e = int'(h[14:10]) - 15;
    if (isZ(h)) return 0.0;
    while (e > 0) begin m = m * 2.0; e--; end
    while (e < 0) begin m = m / 2.0; e++; end
    return h[15] ? -m : m;
  endfunction

  function automatic half_t fromReal(real mag, bit sgn);
    int  e = 0, fi;
    real f, fl;
    if (mag == 0.0) return {sgn, 15'h0};
    while (mag >= 2.0) begin mag = mag / 2.0; e++; end
    while (mag < 1.0)  begin mag = mag * 2.0; e--; end
    f  = mag * 1024.0;
    fl = $floor(f);
    fi = $rtoi(fl);
    if ((f - fl > 0.5) || ((f - fl == 0.5) && (fi % 2 == 1))) fi++;
    if (fi == 2048) begin fi = 1024; e++; end
    if (e + 15 < 1)   return {sgn, 15'h0};
    if (e + 15 >= 31) return {sgn, 15'h7C00};
    return {sgn, 5'(e + 15), 10'(fi - 1024)};
  endfunction

  function automatic half_t refMul(half_t a, half_t b);
    bit s = a[15] ^ b[15];
    real v;
    if (isNan(a) || isNan(b) || (isInf(a) && isZ(b)) || (isInf(b) && isZ(a))) return 16'h7E00;
    if (isInf(a) || isInf(b)) return {s, 15'h7C00};
    if (isZ(a) || isZ(b))     return {s, 15'h0};
    v = toReal(a) * toReal(b);
    return fromReal(v < 0.0 ? -v : v, s);
  endfunction

  function automatic half_t refAdd(half_t a, half_t b);
    real v;
    if (isNan(a) || isNan(b)) return 16'h7E00;
    if (isInf(a) && isInf(b)) return (a[15] != b[15]) ? 16'h7E00 : a;
    if (isInf(a)) return a;
    if (isInf(b)) return b;
    if (isZ(a) && isZ(b)) return {a[15] & b[15], 15'h0};
    if (isZ(a)) return b;
    if (isZ(b)) return a;
    v = toReal(a) + toReal(b);
    if (v == 0.0) return 16'h0000;
    return fromReal(v < 0.0 ? -v : v, v < 0.0);
  endfunction

  function automatic half_t lane(logic [127:0] v, int idx);
    return v[idx*16 +: 16];
  endfunction

  function automatic logic [127:0] refVec(logic [127:0] a, logic [127:0] b, logic [127:0] acc);
    logic [127:0] r;
    for (int e = 0; e < 8; e++) begin
      int s, i, j;
      half_t p0, p1;
      s  = e / 4; i = (e % 4) / 2; j = e % 2;
      p0 = refMul(lane(a, 4*s + 2*i),     lane(b, 4*s + 2*j));
      p1 = refMul(lane(a, 4*s + 2*i + 1), lane(b, 4*s + 2*j + 1));
      r[e*16 +: 16] = refAdd(lane(acc, e), refAdd(p0, p1));
    end
    return r;
  endfunction

  function automatic half_t randHalf();
    if ($urandom % 10 == 0) return 16'($urandom);
    return {1'($urandom), 5'(10 + $urandom % 11), 10'($urandom)};
  endfunction

  function automatic logic [127:0] randVec();
    logic [127:0] v;
    for (int k = 0; k < 8; k++) v[k*16 +: 16] = randHalf();
    return v;
  endfunction

  // ---------------- one operation through the handshake
  task automatic runOp(input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc,
                       input bit feat, input string tag, output logic [127:0] got);
    logic [127:0] exp;
    int lat, hold;
    exp = feat ? refVec(a, b, acc) : acc;
    @(negedge clk);
    check(inReady === 1'b1, "R8", "inReady while idle", 128'(inReady), 128'd1);
    opA = a; opB = b; opAcc = acc; featEn = feat; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0; opA = ~a; opB = ~b; opAcc = ~acc; featEn = ~feat;
    lat = 0;
    while (!outValid && lat < 100) begin @(negedge clk); lat++; end
    got = result;
    if (feat) check(lat == 32, "R8", "edges from accept to outValid", 128'(lat), 128'd32);
    else      check(lat == 0,  "R7", "undefined result one cycle after accept", 128'(lat), 128'd0);
    check(undefFlag === !feat, "R7", "undefFlag", 128'(undefFlag), 128'(!feat));
    check(got === exp, tag, feat ? "result vs reference" : "accumulator passed through", got, exp);
    hold = $urandom % 3;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(outValid && result === got, "R8", "result held without outReady", result, got);
    end
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    outReady = 1'b0;
    check(!outValid && inReady, "R8", "idle after outReady", 128'({outValid, inReady}), 128'b01);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [127:0] got, a, b, acc;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(!outValid && inReady && !undefFlag, "R8", "reset state",
          128'({outValid, inReady, undefFlag}), 128'b010);

    // R1: identity A gives the transpose of B; the two segments differ
    a = {16'h3C00, 16'h0, 16'h0, 16'h4000,  16'h3C00, 16'h0, 16'h0, 16'h3C00};
    b = {16'h4400, 16'h4200, 16'h4000, 16'h3C00, 16'hC400, 16'h4500, 16'h3800, 16'h3400};
    runOp(a, b, '0, 1'b1, "R1", got);
    check(got[15:0] == 16'h3400 && got[31:16] == 16'h4500 && got[47:32] == 16'h3800,
          "R1", "segment 0 transpose lanes", {80'h0, got[47:0]}, {80'h0, 16'h3800, 16'h4500, 16'h3400});

    // R2: ties in the accumulate step: 2048+1 -> 2048, 2050+1 -> 2052
    a = {64'h0, 16'h0, 16'h0, 16'h0, 16'h3C00};
    b = {64'h0, 16'h0, 16'h3C00, 16'h0, 16'h3C00};
    acc = {64'h0, 16'h0, 16'h0, 16'h6801, 16'h6800};
    runOp(a, b, acc, 1'b1, "R2", got);
    check(got[31:0] == 32'h6802_6800, "R2", "ties to even", {96'h0, got[31:0]}, {96'h0, 32'h6802_6800});

    // R6: exact cancellation gives +0; -0 + -0 stays -0
    a = {64'h0, 16'h0, 16'h0, 16'h3C00, 16'h3C00};
    b = {64'h0, 16'h8000, 16'h8000, 16'hBC00, 16'h3C00};
    acc = {64'h0, 16'h0, 16'h0, 16'h8000, 16'h8000};
    runOp(a, b, acc, 1'b1, "R6", got);
    check(got[31:0] == 32'h8000_0000, "R6", "zero signs", {96'h0, got[31:0]}, {96'h0, 32'h8000_0000});

    // R3: product overflow to signed infinity
    a = {64'h0, 16'h0, 16'h0, 16'h0, 16'hF800};
    b = {64'h0, 16'h0, 16'h0, 16'h0, 16'h7800};
    runOp(a, b, '0, 1'b1, "R3", got);
    check(got[15:0] == 16'hFC00, "R3", "negative overflow", {112'h0, got[15:0]}, {112'h0, 16'hFC00});

    // R4: NaN in segment 0 only, inf*0 in segment 1
    a = {16'h0, 16'h0, 16'h0, 16'h7C00,  16'h0, 16'h0, 16'h3C00, 16'h7C01};
    b = {16'h0, 16'h0, 16'h0, 16'h0,     16'h0, 16'h0, 16'h3C00, 16'h3C00};
    runOp(a, b, '0, 1'b1, "R4", got);
    check(got[15:0] == 16'h7E00 && got[79:64] == 16'h7E00 && got[47:32] == 16'h0000,
          "R4", "default NaN lanes", {got[79:64], got[47:32], got[15:0]}, {16'h7E00, 16'h0000, 16'h7E00});

    // R5: underflowing product and subnormal operands flush to zero
    a = {64'h0, 16'h0, 16'h0, 16'h8200, 16'h0400};
    b = {64'h0, 16'h0, 16'h0, 16'h3C00, 16'h0400};
    acc = {64'h0, 16'h0, 16'h0, 16'h0, 16'h8001};
    runOp(a, b, acc, 1'b1, "R5", got);
    check(got[15:0] == 16'h0000, "R5", "flushed lane", {112'h0, got[15:0]}, 128'h0);

    // R7: feature disabled
    runOp(randVec(), randVec(), 128'hDEAD_BEEF_0123_4567_89AB_CDEF_1357_9BDF, 1'b0, "R7", got);

    // random mix checked against the reference
    for (int n = 0; n < 60; n++) begin
      runOp(randVec(), randVec(), randVec(), ($urandom % 8) != 0, "R1 R2", got);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule